// File: doc/BRIEF.md
# Posted Store Buffer with Whole-Line Writeback

This block sits between a processor's store path and the external system bus. Stores are posted into it through a valid/ready handshake, so the core keeps executing while the buffer pushes the writes out on the bus. Each bus write stays presented until an acknowledge arrives. When an acknowledge arrives and more work is queued, the next entry is presented on the very next clock. There is therefore no idle cycle between consecutive bus writes.

The buffer works in one of two modes. In the first it holds up to four independent doubleword address/data pairs. In the second it holds one complete cache line of four doublewords that is being written back. A line is entered as four handshake beats, and `cpu_line` is set on the first beat. The line address is taken from the first beat with its in-line offset cleared. The four transfers then leave in ascending doubleword order. An empty flag tells the core when every posted write has been acknowledged, which it needs before an ordering-sensitive operation.

The control is a three-state machine:
- OPEN: the buffer accepts single writes, or accepts a line start when it is empty.
- FILL: the buffer is capturing line beats 2 to 4.
- DRAIN: the whole line is held and the processor side is closed.

The transitions are:
- OPEN→FILL (line start): a line-marked beat is accepted.
- FILL→DRAIN (line captured): the fourth beat is accepted.
- DRAIN→OPEN (line retired): the last held entry is acknowledged.

Top module: `store_wbuf`

## Requirements
- R1: After reset, `cpu_ready`=1, `cpu_empty`=1 and `bus_valid`=0.
- R2: Up to four single writes (`cpu_line`=0) are accepted with no bus acknowledge. While four entries are held, `cpu_ready` is 0.
- R3: Entries are presented on the bus oldest first, with the address and data they were accepted with. While `bus_valid`=1 and `bus_ack`=0, `bus_addr` and `bus_data` hold steady.
- R4: An entry leaves only in a cycle where `bus_valid`=1 and `bus_ack`=1. `bus_ack` while `bus_valid`=0 changes nothing.
- R5: If an acknowledge retires an entry and at least one more is held, `bus_valid` stays 1 in the next cycle and the next entry is presented there. Writes go out with zero dead clocks.
- R6: In OPEN, a beat with `cpu_line`=1 sees `cpu_ready`=0 unless the buffer holds no entry.
- R7: A line started with address A produces bus writes to L, L+8, L+16 and L+24, where L is A with bits [4:0] cleared. The writes carry the data of beats 1 to 4 in that order.
- R8: From the cycle after the fourth line beat is accepted until the last line entry is acknowledged, `cpu_ready`=0, so no single write is taken. In the cycle after that acknowledge, `cpu_ready` returns to 1.
- R9: `cpu_empty`=1 exactly when no entry is held and no line is part-way through capture.
- R10: On line beats 2 to 4, the values of `cpu_line` and `cpu_addr` have no effect on the bus addresses produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_valid | input | 1 | Processor offers a write beat |
| cpu_ready | output | 1 | Buffer takes the beat this cycle |
| cpu_line | input | 1 | Beat starts a whole-line writeback |
| cpu_addr | input | ADDR_W | Byte address of the write |
| cpu_data | input | DATA_W | Doubleword to write |
| cpu_empty | output | 1 | All posted writes have completed |
| bus_valid | output | 1 | A bus write cycle is presented |
| bus_addr | output | ADDR_W | Address of the presented write |
| bus_data | output | DATA_W | Data of the presented write |
| bus_ack | input | 1 | Bus accepts the presented write |

## Verification
A behavioural queue model in the bench predicts the processor-side ready and empty signals and the presented bus write on every clock. The stimulus is arranged so that each pattern isolates one behaviour:
- Single writes with the acknowledge held low show the capacity limit and confirm that nothing leaves without an acknowledge.
- A continuous acknowledge over a full buffer separates back-to-back issue from a design that inserts an idle cycle.
- A misaligned line start with junk addresses and markers on the later beats shows the line alignment, the ascending order, and that the later beats' address and marker are ignored.
- Line beats offered to a buffer that is not empty, and single writes offered during a drain, expose wrong admission.
- A long pseudo-random mix of all inputs covers the interleavings between the cases above.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;

    typedef enum logic [1:0] {
        S_OPEN  = 2'd0,
        S_FILL  = 2'd1,
        S_DRAIN = 2'd2
    } wbuf_state_e;

endpackage

// File: rtl/wbuf_slots.sv
module wbuf_slots #(
    parameter int DEPTH = 4,
    parameter int W     = 96
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [W-1:0]                 din,
    input  logic                         pop,
    output logic [W-1:0]                 dout,
    output logic [$clog2(DEPTH+1)-1:0]   count
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH+1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        if (p == PTR_W'(DEPTH-1)) begin
            return '0;
        end
        return p + PTR_W'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                wr_ptr <= bump(wr_ptr);
            end
            if (pop) begin
                rd_ptr <= bump(rd_ptr);
            end
            unique case ({push, pop})
                2'b10:   count <= count + CNT_W'(1);
                2'b01:   count <= count - CNT_W'(1);
                default: count <= count;
            endcase
        end
    end

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (push && wr_ptr == PTR_W'(g)) begin
                mem[g] <= din;
            end
        end
    end

    assign dout = mem[rd_ptr];

endmodule

// File: rtl/wbuf_lineaddr.sv
module wbuf_lineaddr #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 64,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_start,
    input  logic              line_step,
    input  logic              in_fill,
    input  logic              cpu_line,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic [ADDR_W-1:0] push_addr,
    output logic              last_beat
);
    localparam int WORD_BYTES = DATA_W / 8;
    localparam int WORD_SH    = $clog2(WORD_BYTES);
    localparam int OFFS_W     = $clog2(DEPTH * WORD_BYTES);
    localparam int BEAT_W     = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [ADDR_W-1:0] base_q;
    logic [BEAT_W-1:0] beat_q;
    logic [ADDR_W-1:0] aligned;

    assign aligned = {cpu_addr[ADDR_W-1:OFFS_W], {OFFS_W{1'b0}}};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            beat_q <= '0;
        end else if (line_start) begin
            base_q <= aligned;
            beat_q <= BEAT_W'(1);
        end else if (line_step) begin
            beat_q <= beat_q + BEAT_W'(1);
        end
    end

    always_comb begin
        if (in_fill) begin
            push_addr = base_q + (ADDR_W'(beat_q) << WORD_SH);
        end else if (cpu_line) begin
            push_addr = aligned;
        end else begin
            push_addr = cpu_addr;
        end
    end

    assign last_beat = (beat_q == BEAT_W'(DEPTH-1));

endmodule

// File: rtl/wbuf_ctrl.sv
module wbuf_ctrl
    import wbuf_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cpu_valid,
    input  logic                       cpu_line,
    input  logic [$clog2(DEPTH+1)-1:0] occ,
    input  logic                       pop,
    input  logic                       last_beat,
    output logic                       cpu_ready,
    output logic                       push,
    output logic                       line_start,
    output logic                       line_step,
    output logic                       in_fill,
    output logic                       cpu_empty
);
    localparam int CNT_W = $clog2(DEPTH+1);

    wbuf_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_OPEN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_OPEN: begin
                if (line_start) state_d = S_FILL;
            end
            S_FILL: begin
                if (push && last_beat) state_d = S_DRAIN;
            end
            S_DRAIN: begin
                if (pop && occ == CNT_W'(1)) state_d = S_OPEN;
            end
            default: state_d = S_OPEN;
        endcase
    end

    always_comb begin
        cpu_ready = 1'b0;
        in_fill   = 1'b0;
        unique case (state_q)
            S_OPEN: begin
                cpu_ready = (occ < CNT_W'(DEPTH)) && !(cpu_line && occ != '0);
            end
            S_FILL: begin
                cpu_ready = 1'b1;
                in_fill   = 1'b1;
            end
            S_DRAIN: begin
                cpu_ready = 1'b0;
            end
            default: cpu_ready = 1'b0;
        endcase
        push       = cpu_valid && cpu_ready;
        line_start = push && (state_q == S_OPEN) && cpu_line;
        line_step  = push && (state_q == S_FILL);
        cpu_empty  = (occ == '0) && (state_q != S_FILL);
    end

endmodule

// File: rtl/store_wbuf.sv
module store_wbuf #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 64,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_valid,
    output logic              cpu_ready,
    input  logic              cpu_line,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_data,
    output logic              cpu_empty,
    output logic              bus_valid,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_data,
    input  logic              bus_ack
);
    localparam int CNT_W = $clog2(DEPTH+1);
    localparam int ENT_W = ADDR_W + DATA_W;

    logic [CNT_W-1:0]  occ;
    logic              push;
    logic              pop;
    logic              line_start;
    logic              line_step;
    logic              in_fill;
    logic              last_beat;
    logic [ADDR_W-1:0] push_addr;
    logic [ENT_W-1:0]  head;

    assign bus_valid = (occ != '0);
    assign pop       = bus_valid && bus_ack;
    assign bus_addr  = head[ENT_W-1:DATA_W];
    assign bus_data  = head[DATA_W-1:0];

    wbuf_ctrl #(.DEPTH(DEPTH)) ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_valid  (cpu_valid),
        .cpu_line   (cpu_line),
        .occ        (occ),
        .pop        (pop),
        .last_beat  (last_beat),
        .cpu_ready  (cpu_ready),
        .push       (push),
        .line_start (line_start),
        .line_step  (line_step),
        .in_fill    (in_fill),
        .cpu_empty  (cpu_empty)
    );

    wbuf_lineaddr #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) addr_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_start (line_start),
        .line_step  (line_step),
        .in_fill    (in_fill),
        .cpu_line   (cpu_line),
        .cpu_addr   (cpu_addr),
        .push_addr  (push_addr),
        .last_beat  (last_beat)
    );

    wbuf_slots #(.DEPTH(DEPTH), .W(ENT_W)) slots_i (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (push),
        .din   ({push_addr, cpu_data}),
        .pop   (pop),
        .dout  (head),
        .count (occ)
    );

endmodule

// File: rtl/store_wbuf_chk.sv
module store_wbuf_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 64,
    parameter int DEPTH  = 4
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       cpu_valid,
    input logic                       cpu_ready,
    input logic                       cpu_line,
    input logic                       cpu_empty,
    input logic                       bus_valid,
    input logic [ADDR_W-1:0]          bus_addr,
    input logic [DATA_W-1:0]          bus_data,
    input logic                       bus_ack,
    input logic [$clog2(DEPTH+1)-1:0] occ
);
    localparam int CNT_W = $clog2(DEPTH+1);

    logic       acc;
    logic [3:0] beats;

    assign acc = cpu_valid && cpu_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beats <= '0;
        end else if (acc) begin
            if (beats == 4'd0 && cpu_line && cpu_empty) begin
                beats <= 4'd1;
            end else if (beats != 4'd0) begin
                beats <= (beats == 4'(DEPTH-1)) ? 4'd0 : beats + 4'd1;
            end
        end
    end

    assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= CNT_W'(DEPTH));

    assert_full_closed_R2: assert property (@(posedge clk) disable iff (!rst_n)
        occ == CNT_W'(DEPTH) |-> !cpu_ready);

    assert_hold_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && !bus_ack |=> bus_valid && $stable(bus_addr) && $stable(bus_data));

    assert_no_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && bus_ack && occ > CNT_W'(1) |=> bus_valid);

    assert_line_closed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        beats == 4'(DEPTH-1) && acc |=> !cpu_ready);

    assert_empty_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_empty |-> !bus_valid);

endmodule

bind store_wbuf store_wbuf_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_valid (cpu_valid),
    .cpu_ready (cpu_ready),
    .cpu_line  (cpu_line),
    .cpu_empty (cpu_empty),
    .bus_valid (bus_valid),
    .bus_addr  (bus_addr),
    .bus_data  (bus_data),
    .bus_ack   (bus_ack),
    .occ       (occ)
);

// File: tb/store_wbuf_tb_top.sv
module store_wbuf_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_valid = 1'b0;
    logic        cpu_line = 1'b0;
    logic [31:0] cpu_addr = '0;
    logic [63:0] cpu_data = '0;
    logic        bus_ack = 1'b0;
    logic        cpu_ready;
    logic        cpu_empty;
    logic        bus_valid;
    logic [31:0] bus_addr;
    logic [63:0] bus_data;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    logic [95:0] q[$];
    int          mode = 0;
    int          beat = 0;
    logic [31:0] base = '0;

    always #4 clk = ~clk;

    store_wbuf dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_valid (cpu_valid),
        .cpu_ready (cpu_ready),
        .cpu_line  (cpu_line),
        .cpu_addr  (cpu_addr),
        .cpu_data  (cpu_data),
        .cpu_empty (cpu_empty),
        .bus_valid (bus_valid),
        .bus_addr  (bus_addr),
        .bus_data  (bus_data),
        .bus_ack   (bus_ack)
    );

    task automatic step(input bit v, input bit ln, input logic [31:0] a,
                        input logic [63:0] d, input bit ack, input string tag);
        bit e_ready;
        bit e_empty;
        bit e_valid;
        bit acc;
        bit pop;
        @(negedge clk);
        cpu_valid = v; cpu_line = ln; cpu_addr = a; cpu_data = d; bus_ack = ack;
        #1;
        if (mode == 0)      e_ready = (q.size() < 4) && !(ln && q.size() != 0);
        else if (mode == 1) e_ready = 1'b1;
        else                e_ready = 1'b0;
        e_empty = (q.size() == 0) && (mode != 1);
        e_valid = (q.size() != 0);
        vectors++;
        if (cpu_ready !== e_ready) begin
            errors++; $display("FAIL %s cpu_ready act=%0b exp=%0b", tag, cpu_ready, e_ready);
        end
        if (cpu_empty !== e_empty) begin
            errors++; $display("FAIL %s cpu_empty act=%0b exp=%0b", tag, cpu_empty, e_empty);
        end
        if (bus_valid !== e_valid) begin
            errors++; $display("FAIL %s bus_valid act=%0b exp=%0b", tag, bus_valid, e_valid);
        end else if (e_valid && {bus_addr, bus_data} !== q[0]) begin
            errors++; $display("FAIL %s bus write act=%h/%h exp=%h/%h", tag,
                               bus_addr, bus_data, q[0][95:64], q[0][63:0]);
        end
        acc = v && e_ready;
        pop = ack && e_valid;
        if (pop) void'(q.pop_front());
        if (mode == 2 && pop && q.size() == 0) mode = 0;
        if (acc) begin
            if (mode == 0 && !ln) begin
                q.push_back({a, d});
            end else if (mode == 0) begin
                base = a & 32'hFFFF_FFE0;
                q.push_back({base, d});
                mode = 1; beat = 1;
            end else begin
                q.push_back({base + 32'(beat * 8), d});
                beat++;
                if (beat == 4) mode = 2;
            end
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // R1: state out of reset
        step(0, 0, 0, 0, 0, "R1");
        step(0, 0, 0, 0, 1, "R1");
        // R2: four singles with no ack, fifth refused
        for (int i = 0; i < 6; i++)
            step(1, 0, 32'h100 + 32'(i * 8), 64'hA000 + 64'(i), 0, "R2");
        // R4: nothing leaves without ack
        step(0, 0, 0, 0, 0, "R4");
        step(0, 0, 0, 0, 0, "R4");
        // R5: continuous ack drains back to back, R3 order
        for (int i = 0; i < 5; i++) step(0, 0, 0, 0, 1, "R5");
        // R4: ack with nothing presented
        step(0, 0, 0, 0, 1, "R4");
        // R3: singles accepted while acking
        for (int i = 0; i < 8; i++)
            step(1, 0, 32'h2000 + 32'(i * 4), 64'hB0 + 64'(i), (i % 3) != 0, "R3");
        for (int i = 0; i < 5; i++) step(0, 0, 0, 0, 1, "R3");
        // R6: line start refused while an entry is held
        step(1, 0, 32'h300, 64'hC1, 0, "R6");
        step(1, 1, 32'h400, 64'hC2, 0, "R6");
        step(1, 1, 32'h400, 64'hC2, 0, "R6");
        step(0, 0, 0, 0, 1, "R6");
        // R7/R10: misaligned line, junk on later beats
        step(1, 1, 32'h1000_0013, 64'h11, 0, "R7");
        step(1, 1, 32'hDEAD_BEEF, 64'h22, 0, "R10");
        step(1, 0, 32'h0000_0008, 64'h33, 0, "R10");
        step(1, 1, 32'h7777_7777, 64'h44, 0, "R10");
        // R8: singles refused during drain
        for (int i = 0; i < 3; i++) step(1, 0, 32'h500, 64'h55, 0, "R8");
        for (int i = 0; i < 6; i++) step(1, 0, 32'h600, 64'h66, i % 2, "R8");
        for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 1, "R8");
        // R9: line with gaps and acks during capture, empty must stay low
        step(1, 1, 32'h2000_0048, 64'h91, 0, "R9");
        step(0, 0, 0, 0, 1, "R9");
        step(0, 0, 0, 0, 1, "R9");
        step(1, 0, 32'h0, 64'h92, 1, "R9");
        step(0, 0, 0, 0, 1, "R9");
        step(1, 0, 32'h0, 64'h93, 1, "R7");
        step(1, 0, 32'h0, 64'h94, 1, "R7");
        for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 1, "R9");
        // pseudo-random mix
        for (int i = 0; i < 3000; i++)
            step(($urandom % 3) != 0, ($urandom % 6) == 0, $urandom,
                 {$urandom, $urandom}, ($urandom % 2) == 0, "R3 mix");
        for (int i = 0; i < 8; i++) step(0, 0, 0, 0, 1, "R9 mix");
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog act=running exp=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

endmodule